// File: doc/BRIEF.md
# I2C Byte-Command Master

This block is a register-driven I2C bus master that carries out one byte-level command at a time. Software loads a clock divider and a transmit byte and sets the enable bit. It then writes a command word that can ask, all at once, for a start (or repeated start), an eight-bit write or read, a choice of acknowledge for a read, and a closing stop. While the command runs, a busy bit in the status register is set. When it clears, the status register holds the acknowledge returned by the slave, and a read byte is available in the receive register.

Both bus lines are open-drain. The block only ever pulls a line low, and it observes the real line level on a separate input. Every bus unit (start, data bit, acknowledge slot, stop) lasts five divider ticks. SCL is low for the first two ticks and released for the last three. SDA changes while SCL is low, except for the deliberate edges of start and stop. A slave that holds SCL low freezes the high phase of the unit.

Top module: `i2cm_master`

## Requirements
- R1: With divider value P = {high byte, low byte}, one divider tick lasts P+1 clocks and the SCL rising edges of consecutive bus units are 5*(P+1) clocks apart when no slave holds SCL.
- R2: Control bit 7 enables the core and reads back as written. While it is clear, command writes are ignored, busy stays 0 and both line drives are released.
- R3: Command bits are 7 start, 6 stop, 5 read, 4 write and 3 NACK. One command runs in this order: start if requested, then the byte if read or write is requested, then stop if requested. When read and write are both set, read is carried out.
- R4: Status bit 1 is set in the cycle after a command is accepted and stays set until the command finishes. A command written while status bit 1 is set is discarded, as is a new transmit value for the byte under way.
- R5: For a write, the transmit byte goes out MSB first, followed by a released acknowledge slot. Status bit 7 takes the sampled slot level, so 1 means the slave did not acknowledge.
- R6: For a read, the master releases SDA for eight bits, gathers them MSB first into the receive register, then drives the acknowledge slot low, or leaves it released when the NACK bit is set.
- R7: Within a data or acknowledge bit, SDA does not change while SCL is released. A start pulls SDA low with SCL high, and a stop releases SDA with SCL high, which leaves both lines released. A start issued after a byte, with no stop between, forms a repeated start.
- R8: While the SCL input stays low after the master releases SCL, the unit does not advance, so the command takes longer by about the time SCL is held.
- R9: Register offsets are: 0 control, 1 command (write) and status (read), 2 transmit, 3 receive, 4 divider low byte, 5 divider high byte. Registers 0, 2, 4 and 5 read back what was written. Unmapped offsets read 0.
- R10: After reset the core is disabled, status reads 0, the divider reads 0xFFFF and both line drives are released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational from reg_addr |
| scl_i | input | 1 | Sensed SCL level |
| sda_i | input | 1 | Sensed SDA level |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |

## Verification
The hardest situation to reach from the ports is a slave holding SCL low in the middle of a byte. The master has already released the line, so its own drive shows nothing wrong, and only the length of the command reveals whether the wait took place. The bench's bus model holds SCL on the third falling edge of a write for a fixed number of clocks. It then compares the command's duration with an identical run that has no hold, and it also checks that the byte seen on the bus is intact. Repeated start and the final NACK read are reached by chaining commands against a slave model that stops driving once it sees a NACK.

// File: rtl/i2cm_pkg.sv
`timescale 1ns/1ps
package i2cm_pkg;
  localparam int BYTE_W   = 8;
  localparam int PHASES   = 5;
  // command word bit positions
  localparam int CMD_STA  = 7;
  localparam int CMD_STO  = 6;
  localparam int CMD_RD   = 5;
  localparam int CMD_WR   = 4;
  localparam int CMD_NACK = 3;
  localparam int CTRL_EN  = 7;
  // register offsets
  localparam int A_CTRL = 0;
  localparam int A_CMD  = 1;
  localparam int A_TX   = 2;
  localparam int A_RX   = 3;
  localparam int A_PLO  = 4;
  localparam int A_PHI  = 5;

  typedef enum logic [2:0] {U_IDLE, U_START, U_BIT, U_ACK, U_STOP} unit_e;

  // SDA level for phases 1..3 and for phase 4 of a unit (1 = released)
  function automatic logic [1:0] unit_levels(unit_e u, logic dbit);
    case (u)
      U_START: return 2'b10;
      U_STOP:  return 2'b01;
      U_BIT,
      U_ACK:   return {dbit, dbit};
      default: return 2'b11;
    endcase
  endfunction
endpackage

// File: rtl/i2cm_prescale.sv
`timescale 1ns/1ps
module i2cm_prescale #(
  parameter int PRE_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [PRE_W-1:0] pre,
  output logic             tick
);
  logic [PRE_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)            cnt_q <= '0;
    else if (!run)         cnt_q <= pre;
    else if (cnt_q == '0)  cnt_q <= pre;
    else                   cnt_q <= cnt_q - 1'b1;
  end

  assign tick = run && (cnt_q == '0);
endmodule

// File: rtl/i2cm_bitunit.sv
`timescale 1ns/1ps
module i2cm_bitunit (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic tick,
  input  logic go,
  input  logic d1,
  input  logic d4,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_low,
  output logic sda_low,
  output logic smp,
  output logic done
);
  logic [2:0] ph_q;
  logic       act_q, d1_q, d4_q;
  logic       adv;

  assign adv  = act_q && tick;
  assign done = adv && (ph_q == 3'd4);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph_q <= '0; act_q <= 1'b0; d1_q <= 1'b1; d4_q <= 1'b1;
      scl_low <= 1'b0; sda_low <= 1'b0; smp <= 1'b1;
    end else if (!en) begin
      ph_q <= '0; act_q <= 1'b0;
      scl_low <= 1'b0; sda_low <= 1'b0;
    end else if (go) begin
      ph_q <= '0; act_q <= 1'b1; d1_q <= d1; d4_q <= d4;
      scl_low <= 1'b1;
    end else if (adv) begin
      case (ph_q)
        3'd0: begin sda_low <= ~d1_q; ph_q <= 3'd1; end
        3'd1: begin scl_low <= 1'b0;  ph_q <= 3'd2; end
        3'd2: if (scl_i) ph_q <= 3'd3;
        3'd3: begin smp <= sda_i; sda_low <= ~d4_q; ph_q <= 3'd4; end
        default: begin act_q <= 1'b0; ph_q <= '0; end
      endcase
    end
  end
endmodule

// File: rtl/i2cm_byte_ctrl.sv
`timescale 1ns/1ps
module i2cm_byte_ctrl
  import i2cm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              cmd_wr,
  input  logic [7:0]        cmd,
  input  logic [BYTE_W-1:0] tx,
  input  logic              done,
  input  logic              smp,
  output logic              go,
  output logic              d1,
  output logic              d4,
  output logic              busy,
  output logic              accept,
  output logic              bit_unit,
  output logic [BYTE_W-1:0] rx_byte,
  output logic              rx_ack
);
  localparam int CNT_W = $clog2(BYTE_W) + 1;

  unit_e             st_q, nxt;
  logic [CNT_W-1:0]  cnt_q;
  logic [BYTE_W-1:0] sh_q, sh_n;
  logic              f_sto, f_rd, f_wr, f_nack, dbit;

  assign busy     = (st_q != U_IDLE);
  assign bit_unit = (st_q == U_BIT) || (st_q == U_ACK);
  assign accept   = cmd_wr && en && !busy &&
                    (cmd[CMD_STA] | cmd[CMD_STO] | cmd[CMD_RD] | cmd[CMD_WR]);

  always_comb begin
    nxt  = st_q;
    sh_n = sh_q;
    dbit = 1'b1;
    if (accept) begin
      sh_n = tx;
      dbit = cmd[CMD_RD] ? 1'b1 : tx[BYTE_W-1];
      if (cmd[CMD_STA])                     nxt = U_START;
      else if (cmd[CMD_RD] || cmd[CMD_WR])  nxt = U_BIT;
      else                                  nxt = U_STOP;
    end else if (done) begin
      case (st_q)
        U_START: begin
          nxt  = (f_rd || f_wr) ? U_BIT : (f_sto ? U_STOP : U_IDLE);
          dbit = f_rd ? 1'b1 : sh_q[BYTE_W-1];
        end
        U_BIT: begin
          sh_n = {sh_q[BYTE_W-2:0], smp};
          if (cnt_q == CNT_W'(BYTE_W-1)) begin
            nxt  = U_ACK;
            dbit = f_rd ? f_nack : 1'b1;
          end else begin
            dbit = f_rd ? 1'b1 : sh_n[BYTE_W-1];
          end
        end
        U_ACK:   nxt = f_sto ? U_STOP : U_IDLE;
        default: nxt = U_IDLE;
      endcase
    end
    go       = (accept || done) && (nxt != U_IDLE);
    {d1, d4} = unit_levels(nxt, dbit);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q <= U_IDLE; cnt_q <= '0; sh_q <= '0;
      f_sto <= 1'b0; f_rd <= 1'b0; f_wr <= 1'b0; f_nack <= 1'b0;
      rx_byte <= '0; rx_ack <= 1'b0;
    end else if (!en) begin
      st_q <= U_IDLE;
    end else begin
      st_q <= nxt;
      sh_q <= sh_n;
      if (accept) begin
        f_sto  <= cmd[CMD_STO];
        f_rd   <= cmd[CMD_RD];
        f_wr   <= cmd[CMD_WR];
        f_nack <= cmd[CMD_NACK];
        cnt_q  <= '0;
      end else if (done && st_q == U_BIT) begin
        cnt_q <= cnt_q + 1'b1;
      end
      if (done && st_q == U_ACK) begin
        if (f_rd) rx_byte <= sh_q;
        else      rx_ack  <= smp;
      end
    end
  end
endmodule

// File: rtl/i2cm_master.sv
`timescale 1ns/1ps
module i2cm_master
  import i2cm_pkg::*;
#(
  parameter int PRE_W  = 16,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              scl_oe,
  output logic              sda_oe
);
  localparam int HI_W = PRE_W - 8;

  logic             en_q;
  logic [PRE_W-1:0] pre_q;
  logic [7:0]       tx_q, rx_w;
  logic             cmd_wr_w, busy_w, accept_w, bit_unit_w, rx_ack_w;
  logic             tick_w, go_w, d1_w, d4_w, done_w, smp_w;

  assign cmd_wr_w = reg_wr && (reg_addr == ADDR_W'(A_CMD));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q <= 1'b0; pre_q <= '1; tx_q <= '0;
    end else if (reg_wr) begin
      case (reg_addr)
        ADDR_W'(A_CTRL): en_q <= reg_wdata[CTRL_EN];
        ADDR_W'(A_TX):   tx_q <= reg_wdata;
        ADDR_W'(A_PLO):  pre_q[7:0] <= reg_wdata;
        ADDR_W'(A_PHI):  pre_q[PRE_W-1:8] <= reg_wdata[HI_W-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    case (reg_addr)
      ADDR_W'(A_CTRL): reg_rdata = {en_q, 7'b0};
      ADDR_W'(A_CMD):  reg_rdata = {rx_ack_w, 5'b0, busy_w, 1'b0};
      ADDR_W'(A_TX):   reg_rdata = tx_q;
      ADDR_W'(A_RX):   reg_rdata = rx_w;
      ADDR_W'(A_PLO):  reg_rdata = pre_q[7:0];
      ADDR_W'(A_PHI):  reg_rdata = 8'(pre_q >> 8);
      default:         reg_rdata = 8'h00;
    endcase
  end

  i2cm_prescale #(.PRE_W(PRE_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .run(busy_w), .pre(pre_q), .tick(tick_w)
  );

  i2cm_byte_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .en(en_q), .cmd_wr(cmd_wr_w), .cmd(reg_wdata),
    .tx(tx_q), .done(done_w), .smp(smp_w), .go(go_w), .d1(d1_w), .d4(d4_w),
    .busy(busy_w), .accept(accept_w), .bit_unit(bit_unit_w),
    .rx_byte(rx_w), .rx_ack(rx_ack_w)
  );

  i2cm_bitunit u_bit (
    .clk(clk), .rst_n(rst_n), .en(en_q), .tick(tick_w), .go(go_w),
    .d1(d1_w), .d4(d4_w), .scl_i(scl_i), .sda_i(sda_i),
    .scl_low(scl_oe), .sda_low(sda_oe), .smp(smp_w), .done(done_w)
  );
endmodule

// File: rtl/i2cm_master_sva.sv
`timescale 1ns/1ps
module i2cm_master_sva (
  input logic clk,
  input logic rst_n,
  input logic en,
  input logic busy,
  input logic accept,
  input logic bit_unit,
  input logic scl_oe,
  input logic sda_oe
);
  // R7: data and acknowledge bits keep SDA steady while SCL is released
  p_sda_steady_scl_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_unit && $past(bit_unit) && !scl_oe && !$past(scl_oe)) |-> $stable(sda_oe));

  // R4: busy only rises from an accepted command
  p_busy_from_accept_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(accept));

  // R2: a disabled core releases both lines
  p_released_when_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!scl_oe && !sda_oe));

  // R4: SCL is pulled only while a command runs
  p_scl_only_in_cmd_r4: assert property (@(posedge clk) disable iff (!rst_n)
    scl_oe |-> busy);
endmodule

bind i2cm_master i2cm_master_sva u_sva (
  .clk(clk), .rst_n(rst_n), .en(en_q), .busy(busy_w), .accept(accept_w),
  .bit_unit(bit_unit_w), .scl_oe(scl_oe), .sda_oe(sda_oe)
);

// File: tb/tb_i2cm_master.sv
`timescale 1ns/1ps
module tb_i2cm_master;
  logic       clk = 1'b0, rst_n = 1'b0, reg_wr = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0, reg_rdata;
  logic       scl_oe, sda_oe;
  logic       slv_hold = 1'b0, stretch_hold = 1'b0;
  wire        scl_bus = !(scl_oe || stretch_hold);
  wire        sda_bus = !(sda_oe || slv_hold);

  int n_tests = 0, n_fail = 0;
  int starts = 0, stops = 0, idx = 0;
  logic [7:0] mon_sh = '0, mon_byte = '0, slv_byte = '0;
  logic mon_ack = 1'b0, slv_ack_en = 1'b0, slv_tx_on = 1'b0;
  longint t_prev = 0, gap = 0;

  always #5 clk = ~clk;

  i2cm_master dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .scl_i(scl_bus),
    .sda_i(sda_bus), .scl_oe(scl_oe), .sda_oe(sda_oe)
  );

  // bus monitor and slave model
  always @(negedge sda_bus) if (scl_bus === 1'b1) begin starts++; idx = 0; end
  always @(posedge sda_bus) if (scl_bus === 1'b1) begin stops++; idx = 0; slv_tx_on = 1'b0; end
  always @(posedge scl_bus) begin
    gap = $time - t_prev; t_prev = $time;
    if (idx < 8) mon_sh = {mon_sh[6:0], sda_bus};
    else begin
      mon_byte = mon_sh; mon_ack = sda_bus;
      if (slv_tx_on && sda_bus) slv_tx_on = 1'b0;
    end
    idx = (idx >= 8) ? 0 : idx + 1;
  end
  always @(negedge scl_bus) begin
    if (idx < 8) slv_hold = slv_tx_on && !slv_byte[3'(7 - idx)];
    else         slv_hold = slv_ack_en && !slv_tx_on;
  end

  task automatic check(string req, string what, longint act, longint exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wr_reg(logic [2:0] a, logic [7:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd_reg(logic [2:0] a, output logic [7:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic wait_idle(output int cyc);
    logic [7:0] s;
    cyc = 0;
    do begin rd_reg(3'd1, s); cyc++; end while (s[1] && cyc < 20000);
    if (cyc >= 20000) check("R4", "command never finished", 1, 0);
  endtask

  task automatic run_cmd(logic [7:0] c, output int cyc);
    wr_reg(3'd1, c); wait_idle(cyc);
  endtask

  task automatic t_reset;
    logic [7:0] d;
    rd_reg(3'd0, d); check("R10", "ctrl after reset", d, 8'h00);
    rd_reg(3'd1, d); check("R10", "status after reset", d, 8'h00);
    rd_reg(3'd4, d); check("R10", "divider low", d, 8'hFF);
    rd_reg(3'd5, d); check("R10", "divider high", d, 8'hFF);
    check("R10", "lines released", {scl_oe, sda_oe}, 0);
  endtask

  task automatic t_regs;
    logic [7:0] d;
    wr_reg(3'd4, 8'h03); wr_reg(3'd5, 8'h00);
    rd_reg(3'd4, d); check("R9", "divider low readback", d, 8'h03);
    rd_reg(3'd5, d); check("R9", "divider high readback", d, 8'h00);
    wr_reg(3'd0, 8'h80); rd_reg(3'd0, d); check("R2", "enable readback", d, 8'h80);
    wr_reg(3'd2, 8'h5A); rd_reg(3'd2, d); check("R9", "tx readback", d, 8'h5A);
    rd_reg(3'd7, d); check("R9", "unmapped offset", d, 8'h00);
  endtask

  task automatic t_write_ack;
    logic [7:0] d; int c; int s0;
    slv_ack_en = 1'b1; s0 = starts;
    wr_reg(3'd2, 8'h54); run_cmd(8'h90, c);
    check("R5", "byte on bus", mon_byte, 8'h54);
    check("R3", "start generated", starts, s0 + 1);
    rd_reg(3'd1, d); check("R5", "ack status", d[7], 0);
    check("R1", "unit spacing P=3", gap, 200);
  endtask

  task automatic t_write_nack_stop;
    logic [7:0] d; int c; int p0;
    slv_ack_en = 1'b0; p0 = stops;
    wr_reg(3'd2, 8'hC3); run_cmd(8'h50, c);
    rd_reg(3'd1, d); check("R5", "no-ack status", d[7], 1);
    check("R5", "byte on bus", mon_byte, 8'hC3);
    check("R3", "stop after byte", stops, p0 + 1);
    check("R7", "bus idle after stop", {scl_bus, sda_bus}, 2'b11);
  endtask

  task automatic t_period;
    int c;
    slv_ack_en = 1'b1;
    wr_reg(3'd4, 8'h07); wr_reg(3'd2, 8'h81); run_cmd(8'hD0, c);
    check("R1", "unit spacing P=7", gap, 400);
    check("R5", "byte at P=7", mon_byte, 8'h81);
    wr_reg(3'd4, 8'h03);
  endtask

  task automatic t_repstart;
    int c; int s0; int p0;
    slv_ack_en = 1'b1; s0 = starts; p0 = stops;
    wr_reg(3'd2, 8'hA4); run_cmd(8'h90, c);
    wr_reg(3'd2, 8'hA5); run_cmd(8'h90, c);
    check("R7", "two starts", starts, s0 + 2);
    check("R7", "no stop between", stops, p0);
    check("R7", "byte after repeated start", mon_byte, 8'hA5);
    run_cmd(8'h40, c);
  endtask

  task automatic t_read;
    logic [7:0] d; int c; int p0;
    slv_ack_en = 1'b0; slv_tx_on = 1'b1; slv_byte = 8'h96;
    run_cmd(8'h20, c);
    rd_reg(3'd3, d); check("R6", "first read byte", d, 8'h96);
    check("R6", "master acked", mon_ack, 0);
    p0 = stops; slv_byte = 8'h3C;
    run_cmd(8'h68, c);
    rd_reg(3'd3, d); check("R6", "last read byte", d, 8'h3C);
    check("R6", "master nacked", mon_ack, 1);
    check("R3", "stop after last read", stops, p0 + 1);
  endtask

  task automatic t_rd_priority;
    logic [7:0] d; int c;
    slv_tx_on = 1'b1; slv_byte = 8'hE1;
    wr_reg(3'd2, 8'h00); run_cmd(8'h78, c);
    rd_reg(3'd3, d); check("R3", "read wins over write", d, 8'hE1);
  endtask

  task automatic t_busy_ignore;
    logic [7:0] d; int c; int p0;
    slv_ack_en = 1'b1; p0 = stops;
    wr_reg(3'd2, 8'hA5); wr_reg(3'd1, 8'h90);
    rd_reg(3'd1, d); check("R4", "busy after accept", d[1], 1);
    wr_reg(3'd1, 8'h40); wr_reg(3'd2, 8'hFF);
    wait_idle(c);
    check("R4", "command during busy dropped", stops, p0);
    check("R4", "byte unaffected by tx write", mon_byte, 8'hA5);
    run_cmd(8'h40, c);
  endtask

  task automatic t_stretch;
    int c0; int c1;
    slv_ack_en = 1'b1;
    wr_reg(3'd2, 8'h33); run_cmd(8'h10, c0);
    fork
      begin
        repeat (3) @(negedge scl_bus);
        stretch_hold = 1'b1;
        repeat (40) @(posedge clk);
        stretch_hold = 1'b0;
      end
    join_none
    run_cmd(8'h10, c1);
    check("R8", "stretch lengthens command", (c1 >= c0 + 24) ? 1 : 0, 1);
    check("R8", "byte intact under stretch", mon_byte, 8'h33);
  endtask

  task automatic t_disabled;
    logic [7:0] d; int s0;
    wr_reg(3'd0, 8'h00); rd_reg(3'd0, d); check("R2", "enable cleared", d, 8'h00);
    s0 = starts;
    wr_reg(3'd1, 8'h90);
    rd_reg(3'd1, d); check("R2", "no busy when disabled", d[1], 0);
    repeat (50) @(negedge clk);
    check("R2", "no start when disabled", starts, s0);
    check("R2", "lines released when disabled", {scl_oe, sda_oe}, 0);
    wr_reg(3'd0, 8'h80);
  endtask

  initial begin
    #2_000_000;
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    starts = 0; stops = 0; idx = 0;
    t_reset;
    t_regs;
    t_write_ack;
    t_write_nack_stop;
    t_period;
    t_repstart;
    t_read;
    t_rd_priority;
    t_busy_ignore;
    t_stretch;
    t_disabled;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule